// File: doc/BRIEF.md
# Sampling Clock Phase Tuning Register File

This block holds the software-visible controls of a sampling-clock phase tuning unit that sits beside an SD/eMMC host datapath. Software sets how many taps the delay line offers, picks one tap, keeps a tap position value, routes the tuned sampling clock into use, and turns automatic re-tuning on and off. The block passes the chosen tap index, the tap enable and the clock route straight to the datapath. The delay line, the card protocol engine and the search for the best tap all sit outside this block.

The datapath reports a re-tune error as a single-cycle pulse. The block stores the pulse in a sticky flag. Software sees the flag only while automatic re-tuning is enabled, and clears it by writing zero to the request register. Registers sit on a simple word-addressed bus. Each register's byte offset is shifted left by a build-time bus shift, so that one register layout serves 16-, 32- and 64-bit register spacing.

Top module: `smpclk_tune_regs`

## Requirements
- R1: After reset, the tap control register reads 0x0008_0000 (tap count 8). Every other register reads zero. `tap_en_o`, `tap_idx_o` and `tune_clk_sel_o` are all 0.
- R2: The bus address is the register offset shifted left by `BUS_SHIFT` (0, 1 or 2). The offsets are: tap control 0x0, tap select 0x2, tap position 0x4, clock route 0x6, re-tune control 0x8, re-tune request 0xA. Any other address, including one with nonzero bits below the shifted offset, reads zero, and a write to it changes nothing.
- R3: Tap control bit 0 is the tap enable and drives `tap_en_o`. Bits 23:16 hold the tap count and can be read and written. All other bits read zero.
- R4: Tap select keeps bits `TAP_W-1:0` of the written word, and `tap_idx_o` shows the new value from the clock edge that takes the write. Before that edge `tap_idx_o` keeps its old value.
- R5: Tap position keeps bits `TAP_W-1:0` of the written word and reads them back. All upper bits read zero.
- R6: Clock route bit 0 drives `tune_clk_sel_o` from the edge that takes the write. Writing 0 removes the tuned clock from use. All other bits read zero.
- R7: Re-tune control bit 0 is the auto re-tune enable and can be read and written. All other bits read zero.
- R8: A one-cycle high on `err_pulse_i` sets a sticky error flag. The flag is stored even while auto re-tune is disabled. Re-tune request bit 2 reads 1 only when the flag is set and re-tune control bit 0 is 1. All other bits of that register read zero.
- R9: A write to re-tune request with data bit 2 equal to 0 clears the flag. A write with data bit 2 equal to 1 leaves the flag as it is. If an error pulse arrives in the same cycle as a clearing write, the flag ends up set.
- R10: Read data is combinational: `rdata_o` shows the addressed register in the same cycle that `req_i` is high and `we_i` is low, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address (offset shifted by BUS_SHIFT) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| err_pulse_i | input | 1 | Re-tune error pulse from the datapath |
| tap_en_o | output | 1 | Tap enable to the delay line |
| tap_idx_o | output | TAP_W | Selected tap index |
| tune_clk_sel_o | output | 1 | Routes the tuned sampling clock into use |

## Verification
Reads take no cycles: the bench presents the address just after a falling edge and samples `rdata_o` 1 ns later, before the next rising edge. Writes and error pulses are captured at one rising edge, so the bench drives them at a falling edge and checks the register outputs and read-back at the next falling edge. For the tap select, it also checks that `tap_idx_o` has not changed in the moment before that rising edge. The error-flag tests and the same-cycle set-and-clear case follow the same one-edge rule, and each result is read back before the next stimulus is driven.

// File: rtl/smpclk_tune_pkg.sv
package smpclk_tune_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned NREG     = 6;
   localparam int unsigned CNT_LSB  = 16;
   localparam int unsigned CNT_W    = 8;
   localparam int unsigned ERR_BIT  = 2;

   // Register index = byte offset / 2; the order sets the address map.
   typedef enum logic [2:0] {
      RG_TCTL = 3'd0,
      RG_TSEL = 3'd1,
      RG_TPOS = 3'd2,
      RG_CRTE = 3'd3,
      RG_RCTL = 3'd4,
      RG_RREQ = 3'd5
   } reg_idx_e;
endpackage

// File: rtl/smpclk_tune_dec.sv
module smpclk_tune_dec
   import smpclk_tune_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BUS_SHIFT = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NREG-1:0]   hit_o
);
   localparam int unsigned LOW_W = BUS_SHIFT + 1;
   localparam int unsigned IDX_W = ADDR_W - LOW_W;

   logic             aligned;
   logic [IDX_W-1:0] idx;

   assign aligned = (addr_i[LOW_W-1:0] == '0);
   assign idx     = addr_i[ADDR_W-1:LOW_W];

   for (genvar g = 0; g < NREG; g++) begin : g_hit
      assign hit_o[g] = aligned && (idx == IDX_W'(g));
   end
endmodule

// File: rtl/smpclk_tune_sticky.sv
module smpclk_tune_sticky (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_o <= 1'b0;
      else if (set_i)   flag_o <= 1'b1;
      else if (clr_i)   flag_o <= 1'b0;
   end

   a_r8_pulse_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> flag_o);

   a_r9_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/smpclk_tune_regs.sv
module smpclk_tune_regs
   import smpclk_tune_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BUS_SHIFT = 2,
   parameter int unsigned TAP_W     = 8,
   parameter int unsigned DEF_TAPS  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   input  logic              err_pulse_i,
   output logic              tap_en_o,
   output logic [TAP_W-1:0]  tap_idx_o,
   output logic              tune_clk_sel_o
);
   if (BUS_SHIFT > 2) begin : g_chk_shift
      $error("BUS_SHIFT must be 0, 1 or 2");
   end
   if (ADDR_W < BUS_SHIFT + 4) begin : g_chk_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (TAP_W < 1 || TAP_W > 16) begin : g_chk_tap
      $error("TAP_W must be 1..16");
   end
   if (DEF_TAPS >= (1 << CNT_W)) begin : g_chk_def
      $error("DEF_TAPS does not fit the tap count field");
   end

   logic [NREG-1:0]  hit;
   logic             wr, rd;
   logic             tap_en_q, crte_q, rt_en_q, err_flag;
   logic [CNT_W-1:0] tap_cnt_q;
   logic [TAP_W-1:0] tap_sel_q, tap_pos_q;
   logic [DATA_W-1:0] word [NREG];
   logic             unused_wdata;

   assign unused_wdata = ^wdata_i;
   assign wr = req_i && we_i;
   assign rd = req_i && !we_i;

   smpclk_tune_dec #(
      .ADDR_W    (ADDR_W),
      .BUS_SHIFT (BUS_SHIFT)
   ) dec_i (
      .addr_i (addr_i),
      .hit_o  (hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tap_en_q  <= 1'b0;
         tap_cnt_q <= CNT_W'(DEF_TAPS);
         tap_sel_q <= '0;
         tap_pos_q <= '0;
         crte_q    <= 1'b0;
         rt_en_q   <= 1'b0;
      end else if (wr) begin
         if (hit[RG_TCTL]) begin
            tap_en_q  <= wdata_i[0];
            tap_cnt_q <= wdata_i[CNT_LSB +: CNT_W];
         end
         if (hit[RG_TSEL]) tap_sel_q <= wdata_i[TAP_W-1:0];
         if (hit[RG_TPOS]) tap_pos_q <= wdata_i[TAP_W-1:0];
         if (hit[RG_CRTE]) crte_q    <= wdata_i[0];
         if (hit[RG_RCTL]) rt_en_q   <= wdata_i[0];
      end
   end

   smpclk_tune_sticky err_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (err_pulse_i),
      .clr_i  (wr && hit[RG_RREQ] && !wdata_i[ERR_BIT]),
      .flag_o (err_flag)
   );

   always_comb begin
      for (int i = 0; i < NREG; i++) word[i] = '0;
      word[RG_TCTL][0]                  = tap_en_q;
      word[RG_TCTL][CNT_LSB +: CNT_W]   = tap_cnt_q;
      word[RG_TSEL][TAP_W-1:0]          = tap_sel_q;
      word[RG_TPOS][TAP_W-1:0]          = tap_pos_q;
      word[RG_CRTE][0]                  = crte_q;
      word[RG_RCTL][0]                  = rt_en_q;
      word[RG_RREQ][ERR_BIT]            = err_flag && rt_en_q;
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd && hit[i]) rdata_o = rdata_o | word[i];
      end
   end

   assign tap_en_o       = tap_en_q;
   assign tap_idx_o      = tap_sel_q;
   assign tune_clk_sel_o = crte_q;

   a_r4_tap_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && hit[RG_TSEL]) |=> (tap_idx_o == $past(wdata_i[TAP_W-1:0])));

   a_r6_route_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && hit[RG_CRTE]) |=> (tune_clk_sel_o == $past(wdata_i[0])));

   a_r3_enable_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && hit[RG_TCTL]) |=> (tap_en_o == $past(wdata_i[0])));

   a_r2_miss_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && hit == '0) |=> ($stable(tap_idx_o) && $stable(tap_en_o)
                             && $stable(tune_clk_sel_o)));
endmodule

// File: tb/smpclk_tune_regs_tb_top.sv
`timescale 1ns/1ps
module smpclk_tune_regs_tb_top;
   localparam int unsigned SHIFT = 2;
   localparam int unsigned AW    = 8;

   typedef struct packed {
      logic [3:0]  off;
      logic [31:0] wd;
      logic [31:0] ex;
   } vec_t;

   localparam vec_t VEC [9] = '{
      '{4'h0, 32'hFFFF_FFFF, 32'h00FF_0001},
      '{4'h2, 32'hFFFF_FF5A, 32'h0000_005A},
      '{4'h4, 32'h1234_56A7, 32'h0000_00A7},
      '{4'h6, 32'hFFFF_FFFF, 32'h0000_0001},
      '{4'h8, 32'hFFFF_FFFF, 32'h0000_0001},
      '{4'h0, 32'h0008_0000, 32'h0008_0000},
      '{4'h2, 32'h0000_0003, 32'h0000_0003},
      '{4'h6, 32'h0000_0000, 32'h0000_0000},
      '{4'h8, 32'hFFFF_FFFE, 32'h0000_0000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, we = 1'b0, err = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          tap_en, csel;
   logic [7:0]    tap_idx;
   int            n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   smpclk_tune_regs #(.ADDR_W(AW), .BUS_SHIFT(SHIFT), .TAP_W(8), .DEF_TAPS(8)) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we),
      .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata),
      .err_pulse_i (err), .tap_en_o (tap_en), .tap_idx_o (tap_idx),
      .tune_clk_sel_o (csel)
   );

   function automatic logic [AW-1:0] ra(input logic [3:0] off);
      return AW'(off) << SHIFT;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr_raw(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic wr(input logic [3:0] off, input logic [31:0] d);
      wr_raw(ra(off), d);
   endtask

   task automatic rd_raw(input logic [AW-1:0] a, output logic [31:0] d);
      req = 1'b1; we = 1'b0; addr = a;
      #1 d = rdata;
      req = 1'b0;
   endtask

   task automatic rd(input logic [3:0] off, output logic [31:0] d);
      rd_raw(ra(off), d);
   endtask

   task automatic pulse_err();
      @(negedge clk);
      err = 1'b1;
      @(negedge clk);
      err = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'h0, v); chk("R1 tap control reset", v, 32'h0008_0000);
      rd(4'h2, v); chk("R1 tap select reset", v, 32'h0);
      rd(4'h4, v); chk("R1 tap position reset", v, 32'h0);
      rd(4'h6, v); chk("R1 clock route reset", v, 32'h0);
      rd(4'h8, v); chk("R1 re-tune control reset", v, 32'h0);
      rd(4'hA, v); chk("R1 re-tune request reset", v, 32'h0);
      chk("R1 outputs reset", {29'h0, tap_en, csel, |tap_idx}, 32'h0);

      // Table walk: R3 R4 R5 R6 R7 field masks, R10 same-cycle read
      for (int i = 0; i < 9; i++) begin
         wr(VEC[i].off, VEC[i].wd);
         rd(VEC[i].off, v);
         chk($sformatf("table vector %0d (R3 R4 R5 R6 R7 R10)", i), v, VEC[i].ex);
      end
      chk("R4 tap index after table", {24'h0, tap_idx}, 32'h3);

      // R4 timing: unchanged before the edge, new value after it
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = ra(4'h2); wdata = 32'h0000_0021;
      #1 chk("R4 tap index before edge", {24'h0, tap_idx}, 32'h3);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      chk("R4 tap index after edge", {24'h0, tap_idx}, 32'h21);

      // R6 clock route output
      wr(4'h6, 32'h1);
      chk("R6 route set", {31'h0, csel}, 32'h1);
      wr(4'h6, 32'hFFFF_FFFE);
      chk("R6 route cleared", {31'h0, csel}, 32'h0);

      // R3 tap enable output with count kept
      wr(4'h0, 32'h0008_0001);
      chk("R3 tap enable out", {31'h0, tap_en}, 32'h1);
      rd(4'h0, v); chk("R3 tap control readback", v, 32'h0008_0001);

      // R2 unmapped and misaligned accesses
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'hC, v); chk("R2 unmapped read", v, 32'h0);
      wr_raw(ra(4'h2) | AW'(1), 32'h0000_00FF);
      chk("R2 misaligned write ignored", {24'h0, tap_idx}, 32'h21);
      rd_raw(ra(4'h2) | AW'(1), v); chk("R2 misaligned read", v, 32'h0);
      wr_raw(ra(4'h0) | AW'(2), 32'h0000_0000);
      chk("R2 misaligned enable kept", {31'h0, tap_en}, 32'h1);
      rd(4'h4, v); chk("R2 tap position untouched", v, 32'hA7);

      // R8 sticky error gated by auto re-tune enable
      pulse_err();
      rd(4'hA, v); chk("R8 error hidden while disabled", v, 32'h0);
      wr(4'h8, 32'h1);
      rd(4'hA, v); chk("R8 error kept and shown once enabled", v, 32'h4);
      // R9 clearing rules
      wr(4'hA, 32'h4);
      rd(4'hA, v); chk("R9 write with bit 2 set keeps flag", v, 32'h4);
      wr(4'hA, 32'h0);
      rd(4'hA, v); chk("R9 write zero clears flag", v, 32'h0);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = ra(4'hA); wdata = 32'h0; err = 1'b1;
      @(negedge clk);
      req = 1'b0; we = 1'b0; err = 1'b0;
      rd(4'hA, v); chk("R9 pulse wins over same-cycle clear", v, 32'h4);
      wr(4'h8, 32'h0);
      rd(4'hA, v); chk("R8 hidden after disable", v, 32'h0);
      wr(4'h8, 32'h1);
      rd(4'hA, v); chk("R8 still stored", v, 32'h4);

      // R10 no read data without a read request
      req = 1'b0; addr = ra(4'h0);
      #1 chk("R10 idle read data", rdata, 32'h0);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs after second reset", {29'h0, tap_en, csel, |tap_idx}, 32'h0);
      rd(4'h0, v); chk("R1 tap count after second reset", v, 32'h0008_0000);
      wr(4'h8, 32'h1);
      rd(4'hA, v); chk("R1 error flag cleared by reset", v, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule